// File: doc/BRIEF.md
# Round-Trip Clock Offset Estimator

This block estimates how far a local free-running counter sits from a remote reference clock, using request/reply exchanges. On a start pulse it issues a one-cycle request strobe and latches the local counter value in that same cycle as the send stamp. When the reply arrives, it latches the local counter again as the arrival stamp, together with the remote clock value carried in the reply. Transport of the messages is handled elsewhere.

The round trip (arrival minus send, modulo 2^32) is compared against a configurable threshold. A short enough exchange is accepted. The reading instant is then taken as the midpoint of the two stamps, and the block reports the signed deviation of that midpoint from the remote value. It also reports an error bound: half of the round trip left after subtracting twice the configured minimum one-way delay, clamped at zero. A long exchange is retried, up to a parameterized number of attempts. Running out of attempts, or waiting too long for any single reply, ends the measurement with a timeout flag instead.

Top module: `rtt_offset_estimator`

## Requirements
- R1: After reset, busy, done, timedOut and reqSend are low, and deviation and errBound are zero.
- R2: A start pulse while idle makes reqSend high for exactly one cycle, in the following cycle. The send stamp is the localCount value present during that reqSend cycle.
- R3: A reply is taken only while a request is outstanding. The arrival stamp is the localCount value in the replyValid cycle, and replyRemote is captured in that same cycle. A replyValid while idle changes no output.
- R4: An exchange is accepted only when its round trip, (arrival − send) mod 2^32, is strictly less than rttThreshold. Otherwise a new request is issued. Acceptance raises done.
- R5: On acceptance, deviation = (send + (round trip >> 1)) − remote, computed mod 2^32 and read as two's complement.
- R6: On acceptance, errBound = floor((round trip − 2·minDelay) / 2), evaluated without truncating 2·minDelay, and 0 when the round trip is below 2·minDelay.
- R7: A measurement issues at most MAX_ATTEMPTS requests. If all of them are rejected, it ends with timedOut high and done low.
- R8: If no reply arrives within replyTimeout cycles after the request cycle, the measurement ends at once with timedOut high.
- R9: deviation and errBound change only on an acceptance and otherwise hold. A start while busy is ignored. A new start clears done and timedOut.
- R10: done and timedOut are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (taken only while idle) |
| localCount | input | 32 | Local free-running counter used for the stamps |
| reqSend | output | 1 | One-cycle strobe: request leaves now |
| replyValid | input | 1 | Reply arrives this cycle |
| replyRemote | input | 32 | Remote clock value carried by the reply |
| rttThreshold | input | 32 | Round-trip limit for acceptance (exclusive) |
| minDelay | input | 32 | Minimum one-way delay |
| replyTimeout | input | 32 | Cycles to wait for a reply |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Last measurement accepted an exchange |
| timedOut | output | 1 | Last measurement was aborted |
| deviation | output | 32 | Signed midpoint minus remote value |
| errBound | output | 32 | Error bound of the accepted estimate |

## Verification
The assertions watch the cycle-level rules on every cycle: the one-cycle request strobe following a start, the exclusivity of done and timedOut, the cap on requests per measurement, result stability while idle, the presence of a reply two cycles before done rises, and the error bound staying under the threshold. The arithmetic, by contrast, can only be shown by the bench's scenarios, where the expected values are computed from the stamps seen at the ports. These scenarios cover counter wraparound, negative deviation, the clamp at zero, acceptance exactly at the threshold, the retry sequence, and the reply timeout.

// File: rtl/rtoe_pkg.sv
package rtoe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_EVAL
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capT0;        // latch send stamp
    logic capReply;     // latch arrival stamp and remote value
    logic latchResult;  // commit deviation and bound
  } dpStrobe_t;

endpackage

// File: rtl/rtoe_estimate.sv
// Pure combinational estimate from the captured stamps.
module rtoe_estimate #(
  parameter int TS_W = 32
) (
  input  logic [TS_W-1:0] t0,
  input  logic [TS_W-1:0] t1,
  input  logic [TS_W-1:0] remote,
  input  logic [TS_W-1:0] rttThreshold,
  input  logic [TS_W-1:0] minDelay,
  output logic            rttOk,
  output logic [TS_W-1:0] devRaw,
  output logic [TS_W-1:0] bound
);

  logic [TS_W-1:0] rtt;
  logic [TS_W-1:0] midpoint;
  logic [TS_W:0]   twoMin;
  logic [TS_W:0]   rttWide;
  logic            belowFloor;
  logic [TS_W-1:0] stoch;

  always_comb begin
    rtt        = t1 - t0;                    // wraps modulo 2^TS_W
    midpoint   = t0 + (rtt >> 1);            // no carry loss across the wrap
    devRaw     = midpoint - remote;
    twoMin     = {minDelay, 1'b0};
    rttWide    = {1'b0, rtt};
    belowFloor = rttWide < twoMin;
    stoch      = belowFloor ? '0 : (rtt - twoMin[TS_W-1:0]);
    bound      = stoch >> 1;
    rttOk      = rtt < rttThreshold;
  end

endmodule

// File: rtl/rtoe_datapath.sv
module rtoe_datapath
  import rtoe_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [TS_W-1:0]        localCount,
  input  logic [TS_W-1:0]        replyRemote,
  input  logic [TS_W-1:0]        rttThreshold,
  input  logic [TS_W-1:0]        minDelay,
  output logic                   rttOk,
  output logic signed [TS_W-1:0] deviation,
  output logic [TS_W-1:0]        errBound
);

  logic [TS_W-1:0] t0Q;
  logic [TS_W-1:0] t1Q;
  logic [TS_W-1:0] remoteQ;
  logic [TS_W-1:0] devRaw;
  logic [TS_W-1:0] boundRaw;
  logic [TS_W-1:0] devQ;
  logic [TS_W-1:0] errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t0Q     <= '0;
      t1Q     <= '0;
      remoteQ <= '0;
    end else begin
      if (strobe.capT0) t0Q <= localCount;
      if (strobe.capReply) begin
        t1Q     <= localCount;
        remoteQ <= replyRemote;
      end
    end
  end

  rtoe_estimate #(.TS_W(TS_W)) u_est (
    .t0           (t0Q),
    .t1           (t1Q),
    .remote       (remoteQ),
    .rttThreshold (rttThreshold),
    .minDelay     (minDelay),
    .rttOk        (rttOk),
    .devRaw       (devRaw),
    .bound        (boundRaw)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ <= '0;
      errQ <= '0;
    end else if (strobe.latchResult) begin
      devQ <= devRaw;
      errQ <= boundRaw;
    end
  end

  assign deviation = devQ;
  assign errBound  = errQ;

endmodule

// File: rtl/rtoe_control.sv
module rtoe_control
  import rtoe_pkg::*;
#(
  parameter int TS_W         = 32,
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            replyValid,
  input  logic            rttOk,
  input  logic [TS_W-1:0] replyTimeout,
  output dpStrobe_t       strobe,
  output logic            reqSend,
  output logic            busy,
  output logic            done,
  output logic            timedOut
);

  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [ATT_W-1:0] ATT_LAST = ATT_W'(MAX_ATTEMPTS);
  localparam logic [ATT_W-1:0] ATT_ONE  = ATT_W'(1);
  localparam logic [TS_W:0]    WAIT_ONE = (TS_W+1)'(1);

  ctlState_e        state;
  logic [ATT_W-1:0] attemptCnt;
  logic [TS_W-1:0]  waitCnt;
  logic             waitExpired;

  always_comb begin
    waitExpired        = ({1'b0, waitCnt} + WAIT_ONE) >= {1'b0, replyTimeout};
    strobe             = '0;
    strobe.capT0       = (state == ST_SEND);
    strobe.capReply    = (state == ST_WAIT) && replyValid;
    strobe.latchResult = (state == ST_EVAL) && rttOk;
    reqSend            = (state == ST_SEND);
    busy               = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      attemptCnt <= '0;
      waitCnt    <= '0;
      done       <= 1'b0;
      timedOut   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_SEND;
            attemptCnt <= '0;
            done       <= 1'b0;
            timedOut   <= 1'b0;
          end
        end
        ST_SEND: begin
          attemptCnt <= attemptCnt + ATT_ONE;
          waitCnt    <= '0;
          state      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (replyValid) begin
            state <= ST_EVAL;
          end else if (waitExpired) begin
            timedOut <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_EVAL: begin
          if (rttOk) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (attemptCnt == ATT_LAST) begin
            timedOut <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            state <= ST_SEND;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rtt_offset_estimator.sv
module rtt_offset_estimator
  import rtoe_pkg::*;
#(
  parameter int TS_W         = 32,
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [TS_W-1:0]        localCount,
  output logic                   reqSend,
  input  logic                   replyValid,
  input  logic [TS_W-1:0]        replyRemote,
  input  logic [TS_W-1:0]        rttThreshold,
  input  logic [TS_W-1:0]        minDelay,
  input  logic [TS_W-1:0]        replyTimeout,
  output logic                   busy,
  output logic                   done,
  output logic                   timedOut,
  output logic signed [TS_W-1:0] deviation,
  output logic [TS_W-1:0]        errBound
);

  dpStrobe_t strobe;
  logic      rttOk;

  rtoe_control #(.TS_W(TS_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .replyValid   (replyValid),
    .rttOk        (rttOk),
    .replyTimeout (replyTimeout),
    .strobe       (strobe),
    .reqSend      (reqSend),
    .busy         (busy),
    .done         (done),
    .timedOut     (timedOut)
  );

  rtoe_datapath #(.TS_W(TS_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .localCount   (localCount),
    .replyRemote  (replyRemote),
    .rttThreshold (rttThreshold),
    .minDelay     (minDelay),
    .rttOk        (rttOk),
    .deviation    (deviation),
    .errBound     (errBound)
  );

endmodule

// File: rtl/rtoe_checker.sv
module rtoe_checker #(
  parameter int TS_W         = 32,
  parameter int MAX_ATTEMPTS = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            reqSend,
  input logic            replyValid,
  input logic            busy,
  input logic            done,
  input logic            timedOut,
  input logic [TS_W-1:0] deviation,
  input logic [TS_W-1:0] errBound,
  input logic [TS_W-1:0] rttThreshold
);

  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_ATTEMPTS);

  logic [CNT_W-1:0] sendCnt;

  always_ff @(posedge clk) begin
    if (!rstN) sendCnt <= '0;
    else if (start && !busy) sendCnt <= '0;
    else if (reqSend && sendCnt != '1) sendCnt <= sendCnt + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rstN) |-> !busy && !done && !timedOut && !reqSend);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqSend |=> !reqSend);

  assert_send_follows_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> reqSend);

  assert_done_needs_reply_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(replyValid, 2));

  assert_bound_below_thr_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> errBound < rttThreshold);

  assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    sendCnt <= CNT_CAP);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(deviation) && $stable(errBound) && !reqSend));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timedOut));

endmodule

bind rtt_offset_estimator rtoe_checker #(.TS_W(TS_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .reqSend      (reqSend),
  .replyValid   (replyValid),
  .busy         (busy),
  .done         (done),
  .timedOut     (timedOut),
  .deviation    (deviation),
  .errBound     (errBound),
  .rttThreshold (rttThreshold)
);

// File: tb/rtt_offset_estimator_bench.sv
`timescale 1ns/1ps
module rtt_offset_estimator_bench;

  localparam int MAXA = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] localCount;
  logic        reqSend;
  logic        replyValid = 1'b0;
  logic [31:0] replyRemote = '0;
  logic [31:0] rttThreshold = 32'd10;
  logic [31:0] minDelay = '0;
  logic [31:0] replyTimeout = 32'd20;
  logic        busy, done, timedOut;
  logic signed [31:0] deviation;
  logic [31:0] errBound;

  logic        loadCnt = 1'b0;
  logic [31:0] loadVal = '0;
  logic [31:0] step = 32'd1;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // plan per attempt: dly==0 means never reply
  int unsigned dly [8];
  logic [31:0] rem [8];
  logic [31:0] t0Rec [8];
  logic [31:0] t1Rec [8];
  bit          replied [8];
  int          reqCount;
  logic [31:0] expDev = '0;
  logic [31:0] expErr = '0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (loadCnt) localCount <= loadVal;
    else         localCount <= localCount + step;
  end

  rtt_offset_estimator #(.TS_W(32), .MAX_ATTEMPTS(MAXA)) u_rtt_offset_estimator (
    .clk(clk), .rstN(rstN), .start(start), .localCount(localCount),
    .reqSend(reqSend), .replyValid(replyValid), .replyRemote(replyRemote),
    .rttThreshold(rttThreshold), .minDelay(minDelay), .replyTimeout(replyTimeout),
    .busy(busy), .done(done), .timedOut(timedOut),
    .deviation(deviation), .errBound(errBound)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setCount(input logic [31:0] v);
    @(negedge clk); loadVal = v; loadCnt = 1'b1;
    @(negedge clk); loadCnt = 1'b0;
  endtask

  task automatic runMeasure(input bit pokeStart);
    int cd;
    cd = 0;
    reqCount = 0;
    for (int i = 0; i < 8; i++) replied[i] = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int guard = 0; guard < 5000; guard++) begin
      if (replyValid) begin replyValid = 1'b0; start = 1'b0; end
      if (reqSend) begin
        if (reqCount < 8) begin
          t0Rec[reqCount] = localCount;
          cd = int'(dly[reqCount]);
        end else cd = 0;
        reqCount++;
      end else if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          replyValid  = 1'b1;
          replyRemote = rem[reqCount-1];
          t1Rec[reqCount-1]   = localCount;
          replied[reqCount-1] = 1;
          if (pokeStart) start = 1'b1;   // R9: start while busy
        end
      end
      if (!busy && !replyValid) break;
      @(negedge clk);
    end
  endtask

  task automatic checkMeasure(input string tag);
    int expAtt;
    bit expDone, expTo;
    logic [31:0] rtt, mid, twoLo;
    logic [32:0] two;
    expAtt = 0; expDone = 0; expTo = 0;
    for (int a = 0; a < MAXA; a++) begin
      expAtt = a + 1;
      if (!replied[a]) begin expTo = 1; break; end       // R8
      rtt = t1Rec[a] - t0Rec[a];
      if (rtt < rttThreshold) begin                       // R4
        expDone = 1;
        mid    = t0Rec[a] + (rtt >> 1);                   // R5
        expDev = mid - rem[a];
        two    = {minDelay, 1'b0};                        // R6
        twoLo  = two[31:0];
        expErr = ({1'b0, rtt} < two) ? 32'd0 : ((rtt - twoLo) >> 1);
        break;
      end
      if (a == MAXA - 1) expTo = 1;                       // R7
    end
    $display("  %s: attempts %0d done %0b timeout %0b", tag, expAtt, expDone, expTo);
    chk("R7", {tag, " request count"}, 32'(reqCount), 32'(expAtt));
    chk("R4", {tag, " done"}, {31'b0, done}, {31'b0, expDone});
    chk("R8", {tag, " timedOut"}, {31'b0, timedOut}, {31'b0, expTo});
    chk("R5", {tag, " deviation"}, deviation, expDev);
    chk("R6", {tag, " errBound"}, errBound, expErr);
    chk("R10", {tag, " exclusive flags"}, {31'b0, done & timedOut}, 32'd0);
  endtask

  task automatic plan1(input int unsigned d0, input logic [31:0] r0);
    for (int i = 0; i < 8; i++) begin dly[i] = 0; rem[i] = '0; end
    dly[0] = d0; rem[0] = r0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    localCount = 32'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "timedOut", {31'b0, timedOut}, 32'd0);
    chk("R1", "reqSend", {31'b0, reqSend}, 32'd0);
    chk("R1", "deviation", deviation, 32'd0);
    chk("R1", "errBound", errBound, 32'd0);

    // R3: reply while idle is ignored
    replyRemote = 32'h1234_5678; replyValid = 1'b1;
    @(negedge clk); replyValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3", "idle reply busy", {31'b0, busy}, 32'd0);
    chk("R3", "idle reply done", {31'b0, done}, 32'd0);
    chk("R3", "idle reply deviation", deviation, 32'd0);

    // basic accept
    setCount(32'd1000); step = 32'd1;
    rttThreshold = 32'd10; minDelay = 32'd1; replyTimeout = 32'd20;
    plan1(3, 32'd990);
    runMeasure(0); checkMeasure("R4 basic");

    // boundary: rtt == threshold rejected, then rtt below accepted
    plan1(4, 32'd5); dly[1] = 3; rem[1] = 32'd7; rttThreshold = 32'd4; minDelay = 0;
    runMeasure(0); checkMeasure("R4 boundary");

    // wraparound of the local counter
    setCount(32'hFFFF_FFF0); step = 32'd7;
    rttThreshold = 32'd100; minDelay = 32'd3;
    plan1(5, 32'h0000_0004);
    runMeasure(0); checkMeasure("R5 wrap");

    // negative deviation
    setCount(32'd500); step = 32'd2;
    plan1(6, 32'd90000);
    runMeasure(0); checkMeasure("R5 negative");
    chk("R5", "sign bit", {31'b0, deviation[31]}, 32'd1);

    // clamp: large minimum delay, including top bit set
    minDelay = 32'h8000_0001; rttThreshold = 32'd100;
    plan1(7, 32'd400);
    runMeasure(0); checkMeasure("R6 clamp");
    chk("R6", "clamped bound", errBound, 32'd0);

    // all attempts too long: results must hold
    minDelay = 32'd0; rttThreshold = 32'd5; step = 32'd1;
    for (int i = 0; i < 8; i++) begin dly[i] = 9; rem[i] = 32'hDEAD; end
    runMeasure(0); checkMeasure("R7 exhausted");

    // reply timeout on the second attempt
    replyTimeout = 32'd6; rttThreshold = 32'd3;
    plan1(4, 32'd1); dly[1] = 0;
    runMeasure(0); checkMeasure("R8 no reply");

    // start while busy ignored
    replyTimeout = 32'd20; rttThreshold = 32'd50;
    plan1(5, 32'd77); dly[1] = 2; rem[1] = 32'd88;
    rttThreshold = 32'd8; step = 32'd2;
    runMeasure(1); checkMeasure("R9 busy start");
    repeat (4) @(negedge clk);
    chk("R9", "no restart", {31'b0, busy}, 32'd0);

    // random exchanges
    replyTimeout = 32'd20;
    for (int n = 0; n < 40; n++) begin
      step = 32'd1 + ($urandom % 32'd100000);
      setCount($urandom);
      rttThreshold = step * (32'd2 + ($urandom % 32'd9));
      minDelay = $urandom % (rttThreshold + 32'd1);
      for (int i = 0; i < 8; i++) begin
        dly[i] = (($urandom % 32'd12) == 0) ? 0 : (1 + ($urandom % 32'd15));
        rem[i] = $urandom;
      end
      runMeasure(0); checkMeasure("random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule